// File: doc/BRIEF.md
# Cascaded Sticky Interrupt Aggregator

The block collects two kinds of interrupt events (level requests from up to seventeen serial interrupt sources, and single-cycle bus error or event pulses) into one level interrupt output. It does this through two stacked latch stages. Both stages are reached through a 32-bit register bus that accepts only aligned word accesses.

The lower stage latches the sources into a sticky status word. A mask register filters that word, and an enable bit in a control register gates the result. Together they form a single request line. The request line is the only non-zero bit of the upper stage's raw input word. The upper stage latches the masked input bits into its own sticky status word, and the output is high while any upper status bit is set. Software clears status bits at either stage by writing ones. Both stages are re-evaluated on every clock, so a change to a mask or to the enable takes hold one cycle after the write.

Top module: `irq_cascade`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: Register offsets are as follows:
  - 0x30: control, with bit 31 as the enable.
  - 0x34: lower mask.
  - 0x38: lower status.
  - 0x40: error address.
  - 0x50: upper status.
  - 0x54: upper mask.
  - 0x58: polarity.
  - 0x5C: raw input.
  
  A read of any other offset, or of an address whose two low bits are not zero, returns 0xFFFFFFFF. A write to such an address changes nothing.
- R3: While serial source n (`ser_irq[n]`) is high, lower status bit 31−n is set on the next clock edge. The bit stays set after the source drops.
- R4: Event pulses set lower status bits. `evt_pulse[8]` sets bit 10, `evt_pulse[7:2]` set bits 7..2, and `evt_pulse[1:0]` set bits 1..0.
- R5: Writing lower status clears each bit written as 1. A set from a source in the same cycle wins over the clear.
- R6: The lower request is 1 when control bit 31 is 1 and (lower status AND lower mask) is non-zero. Otherwise it is 0. A read of 0x5C returns the request in bit 11 and zeros in all other bits.
- R7: On every clock, upper status becomes upper status OR (raw input AND upper mask). `irq_out` is high whenever upper status is non-zero, so it rises one cycle after the request and mask are both present.
- R8: Writing upper status clears each bit written as 1. Upper status bits stay set after the request goes away.
- R9: The polarity register stores and returns any value and has no effect on the logic.
- R10: Offset 0x40 reads the `err_addr` input. Writes to 0x40 and to 0x5C are ignored.
- R11: A write to a mask or to the enable affects status latching from the clock edge after the write cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ser_irq | input | NSER (17) | Serial interrupt source levels |
| evt_pulse | input | 9 | Error and event pulses |
| err_addr | input | 32 | Error address shown at 0x40 |
| irq_out | output | 1 | Aggregated interrupt level |

## Verification
The hardest situation to reach is an upper status bit that is still set after the lower request that caused it has gone. Reaching it takes four steps: set a lower bit, enable it, latch it upward, then clear or mask the lower stage before clearing the upper one. The same-cycle collision of a write-one-to-clear with a new set from a source is also hard to hit at random. Directed sequences build both situations step by step. Random traffic then biases addresses towards the two status registers and keeps the sources sparse, so that clears, masks and new sets interleave often. Every read and every output value is compared against a bench model.

// File: rtl/irq_cascade.sv
module irq_cascade #(
  parameter int AW      = 8,
  parameter int NSER    = 17,
  parameter int REQ_BIT = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NSER-1:0] ser_irq,
  input  logic [8:0]    evt_pulse,
  input  logic [31:0]   err_addr,
  output logic          irq_out
);
  localparam logic [AW-1:0] A_CTRL  = AW'('h30);
  localparam logic [AW-1:0] A_LMASK = AW'('h34);
  localparam logic [AW-1:0] A_LSTAT = AW'('h38);
  localparam logic [AW-1:0] A_EADDR = AW'('h40);
  localparam logic [AW-1:0] A_USTAT = AW'('h50);
  localparam logic [AW-1:0] A_UMASK = AW'('h54);
  localparam logic [AW-1:0] A_POL   = AW'('h58);
  localparam logic [AW-1:0] A_UIN   = AW'('h5C);

  logic [31:0] ctrl, lo_mask, lo_stat, up_stat, up_mask, pol;
  logic [31:0] set_v, up_in;
  logic        lo_req, wr;

  assign wr     = bus_sel & bus_we;
  assign lo_req = ctrl[31] & (|(lo_stat & lo_mask));
  assign up_in  = 32'(lo_req) << REQ_BIT;
  assign irq_out = |up_stat;

  always_comb begin
    set_v = '0;
    for (int n = 0; n < NSER; n++) set_v[31-n] = ser_irq[n];
    set_v[10]  = evt_pulse[8];
    set_v[7:2] = evt_pulse[7:2];
    set_v[1:0] = evt_pulse[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; lo_mask <= '0; lo_stat <= '0;
      up_stat <= '0; up_mask <= '0; pol <= '0;
    end else begin
      lo_stat <= (lo_stat & ~((wr && bus_addr == A_LSTAT) ? bus_wdata : 32'h0)) | set_v;
      up_stat <= (up_stat & ~((wr && bus_addr == A_USTAT) ? bus_wdata : 32'h0)) | (up_in & up_mask);
      if (wr && bus_addr == A_CTRL)  ctrl    <= bus_wdata;
      if (wr && bus_addr == A_LMASK) lo_mask <= bus_wdata;
      if (wr && bus_addr == A_UMASK) up_mask <= bus_wdata;
      if (wr && bus_addr == A_POL)   pol     <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_LMASK: bus_rdata = lo_mask;
      A_LSTAT: bus_rdata = lo_stat;
      A_EADDR: bus_rdata = err_addr;
      A_USTAT: bus_rdata = up_stat;
      A_UMASK: bus_rdata = up_mask;
      A_POL:   bus_rdata = pol;
      A_UIN:   bus_rdata = up_in;
      default: bus_rdata = 32'hFFFF_FFFF;
    endcase
  end
endmodule

module irq_cascade_chk #(
  parameter int AW   = 8,
  parameter int NSER = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic [NSER-1:0] ser_irq,
  input logic [31:0]   lo_stat,
  input logic [31:0]   up_mask,
  input logic          lo_req,
  input logic          irq_out
);
  p_serial_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_irq[0] |=> lo_stat[31]);
  p_upper_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req && up_mask[11]) |=> irq_out);
  p_sticky_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !(bus_sel && bus_we && bus_addr == AW'('h50))) |=> irq_out);
  p_rise_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(lo_req && up_mask[11]));
  p_unimpl_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == AW'('h44)) |-> bus_rdata == 32'hFFFF_FFFF);
endmodule

bind irq_cascade irq_cascade_chk #(.AW(AW), .NSER(NSER)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ser_irq(ser_irq),
  .lo_stat(lo_stat), .up_mask(up_mask), .lo_req(lo_req), .irq_out(irq_out)
);

// File: tb/tb_irq_cascade.sv
module tb_irq_cascade;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, err_addr = 32'hC0DE_0042;
  logic [16:0] ser_irq = 0;
  logic [8:0] evt_pulse = 0;
  logic irq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_lmask, m_lstat, m_ustat, m_umask, m_pol;

  always #5 clk = ~clk;

  irq_cascade dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_irq(ser_irq), .evt_pulse(evt_pulse), .err_addr(err_addr), .irq_out(irq_out));

  function automatic logic m_req();
    return m_ctrl[31] && ((m_lstat & m_lmask) != 0);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h30: return m_ctrl;
      8'h34: return m_lmask;
      8'h38: return m_lstat;
      8'h40: return err_addr;
      8'h50: return m_ustat;
      8'h54: return m_umask;
      8'h58: return m_pol;
      8'h5C: return {20'h0, m_req(), 11'h0};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] set_bits(logic [16:0] s, logic [8:0] e);
    logic [31:0] v = '0;
    for (int n = 0; n < 17; n++) v[31-n] = s[n];
    v[10] = e[8]; v[7:2] = e[7:2]; v[1:0] = e[1:0];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic sel, logic we, logic [7:0] a,
                      logic [31:0] d, logic [16:0] s, logic [8:0] e);
    logic req;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    ser_irq = s; evt_pulse = e;
    #1;
    check({tag, " irq_out"}, {31'h0, irq_out}, {31'h0, m_ustat != 0});
    if (sel && !we) check({tag, " read"}, bus_rdata, exp_read(a));
    req = m_req();
    @(posedge clk);
    if (sel && we) begin
      if (a == 8'h38) m_lstat &= ~d;
      if (a == 8'h50) m_ustat &= ~d;
      if (a == 8'h30) m_ctrl = d;
      if (a == 8'h34) m_lmask = d;
      if (a == 8'h54) m_umask = d;
      if (a == 8'h58) m_pol = d;
    end
    m_lstat |= set_bits(s, e);
    if (req) m_ustat |= (32'h800 & m_umask);
  endtask

  task automatic rd(string tag, logic [7:0] a);
    step(tag, 1, 0, a, 0, 0, 0);
  endtask
  task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
    step(tag, 1, 1, a, d, 0, 0);
  endtask
  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [10] = '{8'h30, 8'h34, 8'h38, 8'h40, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h44, 8'h31};
    void'($urandom(32'd2024));
    m_ctrl = 0; m_lmask = 0; m_lstat = 0; m_ustat = 0; m_umask = 0; m_pol = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state, R2 unimplemented and unaligned
    foreach (addrs[i]) rd("R1 R2 reset read", addrs[i]);
    // R3 source 0 and 16 set bits 31 and 15, sticky after deassert
    step("R3 src", 0, 0, 0, 0, 17'h10001, 0);
    rd("R3 sticky bits 31 15", 8'h38);
    // R4 event pulses
    step("R4 evt", 0, 0, 0, 0, 0, 9'h1FF);
    rd("R4 evt bits", 8'h38);
    // R6 masked but disabled: no request
    wr("R6 mask", 8'h34, 32'h8000_0000);
    wr("R9 polarity", 8'h58, 32'hFFFF_FFFF);
    wr("R7 upper mask", 8'h54, 32'h0000_0800);
    rd("R6 disabled input", 8'h5C);
    idle("R6 disabled no irq");
    // R11 enable then request next cycle, upper latch following
    wr("R11 enable", 8'h30, 32'h8000_0000);
    rd("R6 input bit 11", 8'h5C);
    idle("R7 latch");
    rd("R7 upper status", 8'h50);
    // R8 lower cleared, upper stays
    wr("R5 clear low", 8'h38, 32'hFFFF_FFFF);
    rd("R6 request gone", 8'h5C);
    idle("R8 upper sticky");
    rd("R8 upper still set", 8'h50);
    wr("R8 clear upper", 8'h50, 32'h800);
    idle("R8 cleared");
    // R5 set wins over clear
    step("R5 collide", 1, 1, 8'h38, 32'h8000_0000, 17'h1, 0);
    rd("R5 set wins", 8'h38);
    wr("R5 clear", 8'h38, 32'h8000_0000);
    // R10 read-only writes ignored
    wr("R10 eaddr write", 8'h40, 32'h1234_5678);
    wr("R10 input write", 8'h5C, 32'hFFFF_FFFF);
    wr("R2 unimpl write", 8'h44, 32'hFFFF_FFFF);
    wr("R2 unaligned write", 8'h35, 32'hFFFF_FFFF);
    rd("R10 eaddr", 8'h40);
    rd("R2 mask unchanged", 8'h34);
    rd("R10 input", 8'h5C);
    // random traffic, R2..R11 via model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a = addrs[$urandom % 10];
      logic [31:0] d = $urandom;
      logic [16:0] s = (($urandom % 8) == 0) ? 17'(1 << ($urandom % 17)) : 17'h0;
      logic [8:0] e = (($urandom % 8) == 0) ? 9'(1 << ($urandom % 9)) : 9'h0;
      if (($urandom % 3) == 0) a = (($urandom % 2) == 0) ? 8'h38 : 8'h50;
      if (a == 8'h30 || a == 8'h54) d = d | (($urandom % 2 == 0) ? 32'h8000_0800 : 0);
      step("R7 random", ($urandom % 4) != 0, $urandom % 2, a, d, s, e);
    end
    rd("R1 final", 8'h50);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule